// File: doc/BRIEF.md
# Circular Windowed First-Ready Picker

This block scans a vector of per-entry ready flags and selects one entry: the first ready one found while walking upward from a start position chosen every cycle. The walk continues past the top entry and wraps back to entry 0. It can also be cut short by a window, so that only a bounded run of entries beginning at the start position competes. A scheduler uses it to issue from a queue whose head moves, or to spread grants by moving the start point between cycles.

The core is combinational. First, the ready vector is rotated so that the start entry sits at position 0, and entries beyond the window are masked. Next, a log-depth prefix AND of the inverted candidate bits finds the first survivor. Finally, the grant is rotated back and encoded. A parameter selects whether the outputs are registered (the default, one cycle of latency with synchronous active-low reset) or driven straight from the logic.

Top module: `circ_ready_picker`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the registered outputs read `pick_valid`=0, `pick_grant`=0 and `pick_idx`=0 after that edge.
- R2: With start 0 and no window limit in force, the lowest-numbered ready entry is chosen.
- R3: With no limit, the chosen entry is the first ready one in the order start, start+1, …, N-1, 0, 1, … start-1.
- R4: With `win_en`=1 and 1 ≤ `win_len` ≤ N-1, only the `win_len` entries at circular distance 0 … `win_len`-1 from start can be chosen. A ready entry outside that span is never granted.
- R5: With `win_en`=1, a `win_len` of 0 or of N or more searches all N entries.
- R6: With `win_en`=0, the value of `win_len` has no effect.
- R7: When no candidate is ready, `pick_valid`=0, `pick_grant` is all zeros and `pick_idx`=0.
- R8: When `pick_valid`=1, `pick_grant` has exactly one bit set, and `pick_idx` is the position of that bit.
- R9: In registered mode, the outputs after a rising edge reflect the inputs sampled at that edge. They hold until the next edge, and every input may change each cycle.
- R10: A start value of N or more (possible when N is not a power of two) acts as start modulo N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| ready | input | N | Ready flag per entry |
| start_idx | input | $clog2(N) | Entry at which the circular search begins |
| win_len | input | $clog2(N)+1 | Window length in entries |
| win_en | input | 1 | Apply the window limit |
| pick_valid | output | 1 | An entry was chosen |
| pick_grant | output | N | One-hot grant of the chosen entry |
| pick_idx | output | $clog2(N) | Encoded index of the chosen entry |

## Verification
A fault in the rotation stages shows as a grant to an entry that is shifted by a fixed power of two, but only for start values that have that bit set. A fault in the prefix levels shows as two grant bits set, or as a later entry winning, but only for ready patterns with a gap that spans that level's distance. A fault in the window mask lets an outside entry win, or suppresses an inside one, only for some lengths. With registered outputs, each of these appears at the ports one edge after the offending inputs. For that reason the bench sweeps every ready pattern against every start, length and enable on a six-entry instance.

// File: rtl/pick_pkg.sv
// Shared definitions for the circular ready picker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pick_pkg;

    // Output stage variant of the picker top.
    typedef enum logic {
        PICK_COMB = 1'b0,
        PICK_REG  = 1'b1
    } pick_out_e;

endpackage

// File: rtl/pick_rotator.sv
// Barrel rotator over an N-bit vector, modulo N.
// With LEFT=0: vec_o[j] = vec_i[(j + amt) mod N], which brings entry amt to position 0.
// With LEFT=1: vec_o[j] = vec_i[(j - amt) mod N], which undoes the above.
// Assumes N >= 2. Each stage rotates by 2^k mod N, so any amt acts as amt mod N.
module pick_rotator #(
    parameter int N    = 8,
    parameter int IW   = $clog2(N),
    parameter bit LEFT = 1'b0
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] amt_i,
    output logic [N-1:0]  vec_o
);

    logic [N-1:0] stage [IW+1];

    assign stage[0] = vec_i;

    for (genvar k = 0; k < IW; k++) begin : g_stage
        localparam int SH = (1 << k) % N;
        for (genvar j = 0; j < N; j++) begin : g_bit
            localparam int SRC = LEFT ? ((j - SH + N) % N) : ((j + SH) % N);
            // Select the shifted or the unshifted bit for this stage.
            assign stage[k+1][j] = amt_i[k] ? stage[k][SRC] : stage[k][j];
        end
    end

    assign vec_o = stage[IW];

endmodule

// File: rtl/pick_prefix_scan.sv
// First-set finder built as a log-depth prefix AND.
// It computes the "nothing set so far" term as an AND of inverted bits and
// doubles the span at each level, in the manner of a parallel-prefix carry network.
// Assumes N >= 2. Position 0 has the highest priority.
module pick_prefix_scan #(
    parameter int N   = 8,
    parameter int LOG = $clog2(N)
) (
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] first_o,
    output logic         any_o
);

    // lvl[s][j] = AND of ~cand over positions max(0, j-2^s+1) .. j
    logic [N-1:0] lvl [LOG+1];

    assign lvl[0] = ~cand_i;

    for (genvar s = 0; s < LOG; s++) begin : g_level
        localparam int D = 1 << s;
        for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= D) begin : g_comb
                // Merge this span with the span D positions below.
                assign lvl[s+1][j] = lvl[s][j] & lvl[s][j-D];
            end else begin : g_pass
                // No lower span is left to merge.
                assign lvl[s+1][j] = lvl[s][j];
            end
        end
    end

    // Position 0 wins whenever it is set.
    assign first_o[0] = cand_i[0];
    for (genvar j = 1; j < N; j++) begin : g_first
        // Any other position wins when it is set and nothing below it is.
        assign first_o[j] = cand_i[j] & lvl[LOG][j-1];
    end

    assign any_o = ~lvl[LOG][N-1];

endmodule

// File: rtl/pick_encoder.sv
// One-hot to binary encoder for the grant vector.
// Assumes at most one bit is set. An all-zero input gives index 0.
module pick_encoder #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  onehot_i,
    output logic [IW-1:0] idx_o
);

    // OR together the positions of all set bits.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_i[i]) idx_o = idx_o | IW'(i);
        end
    end

endmodule

// File: rtl/circ_ready_picker.sv
// Circular windowed first-ready picker, the top of the block.
// It rotates ready so that start_idx lands at position 0, masks positions
// at or beyond win_len when the window applies, finds the first survivor with
// a prefix scan, rotates the grant back and encodes it.
// Assumes N >= 2. A start_idx of N or more acts modulo N.
// OUT_MODE selects registered outputs (synchronous active-low reset) or direct outputs.
module circ_ready_picker #(
    parameter int                  N        = 8,
    parameter pick_pkg::pick_out_e OUT_MODE = pick_pkg::PICK_REG,
    localparam int                 IW       = $clog2(N),
    localparam int                 LW       = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ready,
    input  logic [IW-1:0] start_idx,
    input  logic [LW-1:0] win_len,
    input  logic          win_en,
    output logic          pick_valid,
    output logic [N-1:0]  pick_grant,
    output logic [IW-1:0] pick_idx
);

    logic [N-1:0]  ready_rot;
    logic [N-1:0]  win_mask;
    logic [N-1:0]  cand_rot;
    logic [N-1:0]  first_rot;
    logic          any_c;
    logic [N-1:0]  grant_c;
    logic [IW-1:0] idx_c;
    logic          no_limit;

    // Bring the start entry to position 0.
    pick_rotator #(.N(N), .IW(IW), .LEFT(1'b0)) i_rot_fwd (
        .vec_i (ready),
        .amt_i (start_idx),
        .vec_o (ready_rot)
    );

    // The window is off when disabled, zero length, or N or longer.
    assign no_limit = !win_en || (win_len == '0) || (win_len >= LW'(N));

    for (genvar j = 0; j < N; j++) begin : g_mask
        // Position j in rotated order is inside the window when j < win_len.
        assign win_mask[j] = no_limit || (LW'(j) < win_len);
    end

    assign cand_rot = ready_rot & win_mask;

    // Log-depth first-set search in rotated order.
    pick_prefix_scan #(.N(N)) i_scan (
        .cand_i  (cand_rot),
        .first_o (first_rot),
        .any_o   (any_c)
    );

    // Return the grant to physical order.
    pick_rotator #(.N(N), .IW(IW), .LEFT(1'b1)) i_rot_back (
        .vec_i (first_rot),
        .amt_i (start_idx),
        .vec_o (grant_c)
    );

    pick_encoder #(.N(N), .IW(IW)) i_enc (
        .onehot_i (grant_c),
        .idx_o    (idx_c)
    );

    if (OUT_MODE == pick_pkg::PICK_REG) begin : g_reg
        logic          valid_q;
        logic [N-1:0]  grant_q;
        logic [IW-1:0] idx_q;

        // Sample the picker result, or clear it in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                grant_q <= '0;
                idx_q   <= '0;
            end else begin
                valid_q <= any_c;
                grant_q <= grant_c;
                idx_q   <= idx_c;
            end
        end

        assign pick_valid = valid_q;
        assign pick_grant = grant_q;
        assign pick_idx   = idx_q;

        // Reduced start and effective window length, used by the checks below only.
        int start_m;
        int lim_c;
        always_comb begin
            start_m = int'(start_idx) % N;
            lim_c   = no_limit ? N : int'(win_len);
        end

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (!pick_valid && pick_grant == '0 && pick_idx == '0));

        // R4
        window_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pick_valid |-> (((int'(pick_idx) + N - $past(start_m)) % N) < $past(lim_c)));

        // R9
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (pick_valid == ($past(ready) != '0 && $past(lim_c) == N)) || ($past(lim_c) != N));
    end else begin : g_comb
        assign pick_valid = any_c;
        assign pick_grant = grant_c;
        assign pick_idx   = idx_c;
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ($countones(pick_grant) == 1 && pick_grant[pick_idx]));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> (pick_grant == '0 && pick_idx == '0));

endmodule

// File: tb/test_circ_ready_picker.sv
// Exhaustive bench on a six-entry instance, where start values 6 and 7 exercise the modulo behaviour.
module test_circ_ready_picker;

    localparam int N  = 6;
    localparam int IW = $clog2(N);
    localparam int LW = IW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ready = '0;
    logic [IW-1:0] start_idx = '0;
    logic [LW-1:0] win_len = '0;
    logic          win_en = 1'b0;
    logic          pick_valid;
    logic [N-1:0]  pick_grant;
    logic [IW-1:0] pick_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    circ_ready_picker #(.N(N)) i_circ_ready_picker (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .start_idx  (start_idx),
        .win_len    (win_len),
        .win_en     (win_en),
        .pick_valid (pick_valid),
        .pick_grant (pick_grant),
        .pick_idx   (pick_idx)
    );

    // Compare all three outputs against the expected values; one check per call.
    task automatic check_out(input string tag, input bit ev, input logic [N-1:0] eg, input int ei);
        checks++;
        if (pick_valid !== ev || pick_grant !== eg || int'(pick_idx) != ei) begin
            errors++;
            $display("FAIL %s: got v=%0b g=%b i=%0d, expected v=%0b g=%b i=%0d (ready=%b start=%0d len=%0d en=%0b)",
                     tag, pick_valid, pick_grant, pick_idx, ev, eg, ei, ready, start_idx, win_len, win_en);
        end
    endtask

    // Expected result from the circular scan rule.
    task automatic model(input logic [N-1:0] r, input int s, input int len, input bit en,
                         output bit ev, output logic [N-1:0] eg, output int ei);
        int lim;
        lim = (en && len > 0 && len < N) ? len : N;
        ev = 1'b0; eg = '0; ei = 0;
        for (int d = 0; d < lim; d++) begin
            int p;
            p = (s % N + d) % N;
            if (!ev && r[p]) begin
                ev = 1'b1; eg[p] = 1'b1; ei = p;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        bit ev;
        logic [N-1:0] eg;
        int ei;
        string tag;

        // R1: reset with every entry ready
        ready = '1;
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0, '0, 0);
        @(negedge clk);
        check_out("R1", 1'b0, '0, 0);
        rst_n = 1'b1;

        // Exhaustive sweep: new inputs every cycle (R9), sampled one edge later.
        for (int en = 0; en < 2; en++) begin
            for (int len = 0; len < (1 << LW); len++) begin
                for (int s = 0; s < (1 << IW); s++) begin
                    for (int r = 0; r < (1 << N); r++) begin
                        ready = N'(r); start_idx = IW'(s); win_len = LW'(len); win_en = en[0];
                        model(N'(r), s, len, en[0], ev, eg, ei);
                        if (s >= N)                              tag = "R10";
                        else if (!ev)                            tag = "R7";
                        else if (en != 0 && len > 0 && len < N)  tag = "R4";
                        else if (en != 0)                        tag = "R5";
                        else if (len != 0)                       tag = "R6";
                        else if (s == 0)                         tag = "R2";
                        else                                     tag = "R3";
                        @(negedge clk);
                        check_out(tag, ev, eg, ei);
                        if (ev && $countones(pick_grant) != 1) begin
                            errors++;
                            $display("FAIL R8: got grant=%b, expected one bit", pick_grant);
                        end
                        checks++;
                    end
                end
            end
        end

        // R9: output holds until the next edge, then follows
        ready = N'(1 << 2); start_idx = '0; win_en = 1'b0; win_len = '0;
        @(negedge clk);
        check_out("R9", 1'b1, N'(1 << 2), 2);
        ready = N'(1 << 4);
        #1;
        check_out("R9", 1'b1, N'(1 << 2), 2);
        @(negedge clk);
        check_out("R9", 1'b1, N'(1 << 4), 4);

        // R1: reset asserted mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1", 1'b0, '0, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule